// File: doc/BRIEF.md
# Serial-Loaded Configuration Register Bank

This block takes a write-only three-wire serial stream (data, clock and an active-low load strobe) and turns it into eight parallel configuration registers of unequal widths. Each frame opens with a 3-bit start address and a direction flag, followed by two padding bits. After that, one or more register payloads follow back to back. Each payload is exactly as long as the register it targets. The target address advances by one after every complete payload, so a single frame can stream a run of neighbouring registers.

Received payloads are kept in shadow storage. Every register that was completely received during the frame is copied into the live bank together when the strobe rises. The widest register holds the operating controls. Its channel-select field, power-mode field and clamp-enable bit are decoded onto separate outputs. Its self-clearing reset bit returns the whole bank to zero.

The serial pins are oversampled by the block clock through two-stage synchronisers. A frame-parsing state machine has the states IDLE, ADDR, RNW, PAD, DATA and SKIP:

- IDLE moves to ADDR once the strobe is seen low.
- ADDR moves to RNW after three address bits.
- RNW moves to PAD on a write bit, or to SKIP on a read bit.
- PAD moves to DATA after two bits.
- DATA moves to SKIP when the payload for address 7 completes.
- Every state returns to IDLE when the strobe goes high.

Top module: `scp_regbank`

## Requirements
- R1: The strobe must be low for a frame. While it is low, bits are taken on rising serial-clock edges in this order: three address bits with the least significant first, then a direction bit (0 means write), then two padding bits, then payload bits with the least significant first.
- R2: Payload length depends on the address. Address 0 takes 11 bits, address 1 takes 10, address 2 takes 8, address 3 takes 10, and addresses 4 to 7 take 6 bits each.
- R3: After each complete payload the target address increases by one, so consecutive registers can be written in one frame.
- R4: Once the payload for address 7 is complete, further bits in the same frame are ignored.
- R5: Registers change only after the strobe rises. All completed payloads of the frame then appear together, and registers not written keep their values.
- R6: A payload cut short by a strobe rise is discarded. Complete payloads earlier in the same frame are still committed.
- R7: A frame whose direction bit is 1 changes no register.
- R8: Committing an operation-register value with bit 4 set clears every register, including that bit, on the next block clock.
- R9: `chan_sel` equals operation bits 1:0 and `pwr_mode` equals operation bits 3:2. `clamp_en` is the inverse of operation bit 5.
- R10: After reset, all registers read zero and `clamp_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| load_n | input | 1 | Active-low frame strobe; its rising edge commits |
| op_reg | output | 11 | Operation register (address 0) |
| gain_reg | output | 10 | Gain register (address 1) |
| clamp_reg | output | 8 | Clamp level register (address 2) |
| ctrl_reg | output | 10 | Control register (address 3) |
| pix_gain | output | 24 | Four 6-bit pixel gains; address 4 sits in bits 5:0 |
| chan_sel | output | 2 | Decoded channel selection |
| pwr_mode | output | 2 | Decoded power mode |
| clamp_en | output | 1 | Clamping enabled (operation bit 5 low) |

## Verification
A wrong bit counter or address register in the parser shows up at the ports as payload bits landing in the wrong register, or shifted by one position. The error becomes visible a few block clocks after the strobe rises that ends the frame. A stale shadow mark shows up as a register changing when it was not part of the frame. The reset bit must be seen to clear the bank within one clock of its own commit. Sweeping every start address against every run length exposes each of these faults on the first frame that reaches the faulty register.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
package scp_pkg;
    localparam int ADDR_W   = 3;
    localparam int NREG     = 1 << ADDR_W;
    localparam int LEN_OP   = 11;
    localparam int LEN_GAIN = 10;
    localparam int LEN_CLMP = 8;
    localparam int LEN_CTRL = 10;
    localparam int LEN_PIX  = 6;
    localparam int NPIX     = 4;
    localparam int MAX_W    = LEN_OP;
    localparam int CNT_W    = $clog2(MAX_W + 1);
    localparam int PAD_BITS = 2;
    localparam int RST_BIT  = 4;
    localparam int OBC_BIT  = 5;
    localparam int CH_LSB   = 0;
    localparam int PM_LSB   = 2;

    typedef logic [MAX_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_RNW, ST_PAD, ST_DATA, ST_SKIP
    } scp_state_e;

    function automatic logic [CNT_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
        case (a)
            3'd0:    return CNT_W'(LEN_OP);
            3'd1:    return CNT_W'(LEN_GAIN);
            3'd2:    return CNT_W'(LEN_CLMP);
            3'd3:    return CNT_W'(LEN_CTRL);
            default: return CNT_W'(LEN_PIX);
        endcase
    endfunction
endpackage

// File: rtl/scp_sync.sv
`timescale 1ns/1ps
module scp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_data,
    input  logic ser_clk,
    input  logic load_n,
    output logic bit_s,
    output logic clk_rise,
    output logic load_low,
    output logic load_rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] d_q, c_q, l_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
            c_q <= '0;
            l_q <= '1;
        end else begin
            d_q <= {d_q[DEPTH-2:0], ser_data};
            c_q <= {c_q[DEPTH-2:0], ser_clk};
            l_q <= {l_q[DEPTH-2:0], load_n};
        end
    end

    assign bit_s     = d_q[STAGES-1];
    assign clk_rise  = c_q[STAGES-1] & ~c_q[STAGES];
    assign load_low  = ~l_q[STAGES-1];
    assign load_rise = l_q[STAGES-1] & ~l_q[STAGES];
endmodule

// File: rtl/scp_frame.sv
`timescale 1ns/1ps
module scp_frame
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_s,
    input  logic              clk_rise,
    input  logic              load_low,
    output logic              pay_vld,
    output logic [ADDR_W-1:0] pay_addr,
    output word_t             pay_data
);
    scp_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q, paddr_q;
    word_t             dat_q;
    logic              vld_q;
    logic              last_bit;

    assign last_bit = clk_rise && (cnt_q == reg_len(addr_q) - CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!load_low) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_ADDR;
                ST_ADDR: if (clk_rise && cnt_q == CNT_W'(ADDR_W - 1)) state_d = ST_RNW;
                ST_RNW:  if (clk_rise) state_d = bit_s ? ST_SKIP : ST_PAD;
                ST_PAD:  if (clk_rise && cnt_q == CNT_W'(PAD_BITS - 1)) state_d = ST_DATA;
                ST_DATA: if (last_bit && addr_q == ADDR_W'(NREG - 1)) state_d = ST_SKIP;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters, shifting and payload outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            paddr_q <= '0;
            dat_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (vld_q) dat_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q  <= '0;
                    addr_q <= '0;
                    dat_q  <= '0;
                end
                ST_ADDR: if (clk_rise) begin
                    addr_q[cnt_q[1:0]] <= bit_s;
                    cnt_q <= (cnt_q == CNT_W'(ADDR_W - 1)) ? '0 : cnt_q + CNT_W'(1);
                end
                ST_RNW: if (clk_rise) cnt_q <= '0;
                ST_PAD: if (clk_rise) begin
                    cnt_q <= (cnt_q == CNT_W'(PAD_BITS - 1)) ? '0 : cnt_q + CNT_W'(1);
                end
                ST_DATA: if (clk_rise) begin
                    dat_q[cnt_q] <= bit_s;
                    if (last_bit) begin
                        cnt_q   <= '0;
                        vld_q   <= 1'b1;
                        paddr_q <= addr_q;
                        addr_q  <= addr_q + ADDR_W'(1);
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_SKIP: ;
                default: ;
            endcase
        end
    end

    assign pay_vld  = vld_q;
    assign pay_addr = paddr_q;
    assign pay_data = dat_q;

    assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DATA |-> cnt_q < reg_len(addr_q));

    assert_payload_from_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(state_q) == ST_DATA);

    assert_stop_after_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && paddr_q == ADDR_W'(NREG - 1)) |-> (state_q == ST_SKIP || state_q == ST_IDLE));
endmodule

// File: rtl/scp_bank.sv
`timescale 1ns/1ps
module scp_bank
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pay_vld,
    input  logic [ADDR_W-1:0] pay_addr,
    input  word_t             pay_data,
    input  logic              commit,
    output word_t             bank_o [NREG]
);
    word_t             sh_q [NREG];
    word_t             sh_d [NREG];
    word_t             bank_q [NREG];
    logic [NREG-1:0]   mark_q, mark_d;
    logic [NREG*MAX_W-1:0] bank_flat;
    logic              wipe;

    assign wipe = bank_q[0][RST_BIT];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            sh_d[i]   = sh_q[i];
            mark_d[i] = mark_q[i];
            if (pay_vld && pay_addr == ADDR_W'(i)) begin
                sh_d[i]   = pay_data;
                mark_d[i] = 1'b1;
            end
            bank_flat[i*MAX_W +: MAX_W] = bank_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_q <= '0;
            for (int i = 0; i < NREG; i++) begin
                sh_q[i]   <= '0;
                bank_q[i] <= '0;
            end
        end else begin
            mark_q <= commit ? '0 : mark_d;
            for (int i = 0; i < NREG; i++) begin
                sh_q[i] <= sh_d[i];
                if (wipe)                        bank_q[i] <= '0;
                else if (commit && mark_d[i])    bank_q[i] <= sh_d[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) bank_o[i] = bank_q[i];
    end

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (bank_flat == '0));

    assert_hold_until_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !wipe) |=> $stable(bank_flat));
endmodule

// File: rtl/scp_regbank.sv
`timescale 1ns/1ps
module scp_regbank
    import scp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_data,
    input  logic                    ser_clk,
    input  logic                    load_n,
    output logic [LEN_OP-1:0]       op_reg,
    output logic [LEN_GAIN-1:0]     gain_reg,
    output logic [LEN_CLMP-1:0]     clamp_reg,
    output logic [LEN_CTRL-1:0]     ctrl_reg,
    output logic [NPIX*LEN_PIX-1:0] pix_gain,
    output logic [1:0]              chan_sel,
    output logic [1:0]              pwr_mode,
    output logic                    clamp_en
);
    localparam int PIX_BASE = 4;

    logic              bit_s, clk_rise, load_low, load_rise;
    logic              pay_vld;
    logic [ADDR_W-1:0] pay_addr;
    word_t             pay_data;
    word_t             bank [NREG];

    scp_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .ser_data(ser_data), .ser_clk(ser_clk), .load_n(load_n),
        .bit_s(bit_s), .clk_rise(clk_rise),
        .load_low(load_low), .load_rise(load_rise)
    );

    scp_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .bit_s(bit_s), .clk_rise(clk_rise), .load_low(load_low),
        .pay_vld(pay_vld), .pay_addr(pay_addr), .pay_data(pay_data)
    );

    scp_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .pay_vld(pay_vld), .pay_addr(pay_addr), .pay_data(pay_data),
        .commit(load_rise), .bank_o(bank)
    );

    assign op_reg    = bank[0][LEN_OP-1:0];
    assign gain_reg  = bank[1][LEN_GAIN-1:0];
    assign clamp_reg = bank[2][LEN_CLMP-1:0];
    assign ctrl_reg  = bank[3][LEN_CTRL-1:0];

    for (genvar g = 0; g < NPIX; g++) begin : g_pix
        assign pix_gain[g*LEN_PIX +: LEN_PIX] = bank[PIX_BASE+g][LEN_PIX-1:0];
    end

    assign chan_sel = op_reg[CH_LSB +: 2];
    assign pwr_mode = op_reg[PM_LSB +: 2];
    assign clamp_en = ~op_reg[OBC_BIT];
endmodule

// File: tb/scp_regbank_bench.sv
`timescale 1ns/1ps
module scp_regbank_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, load_n = 1'b1;
    logic [10:0] op_reg;
    logic [9:0]  gain_reg;
    logic [7:0]  clamp_reg;
    logic [9:0]  ctrl_reg;
    logic [23:0] pix_gain;
    logic [1:0]  chan_sel, pwr_mode;
    logic        clamp_en;

    int checks = 0;
    int fails  = 0;
    logic [10:0] exp_r [8];

    always #2 clk = ~clk;

    scp_regbank u_scp_regbank (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .load_n(load_n), .op_reg(op_reg), .gain_reg(gain_reg),
        .clamp_reg(clamp_reg), .ctrl_reg(ctrl_reg), .pix_gain(pix_gain),
        .chan_sel(chan_sel), .pwr_mode(pwr_mode), .clamp_en(clamp_en)
    );

    function automatic int blen(int a);
        case (a)
            0: return 11;
            1: return 10;
            2: return 8;
            3: return 10;
            default: return 6;
        endcase
    endfunction

    function automatic logic [10:0] gen(int a, int s);
        logic [10:0] v;
        v = 11'((s * 73 + a * 29 + 17) ^ (s << 3));
        v = v & 11'((1 << blen(a)) - 1);
        if (a == 0) v[4] = 1'b0;
        return v;
    endfunction

    function automatic logic [10:0] act(int i);
        case (i)
            0: return op_reg;
            1: return {1'b0, gain_reg};
            2: return {3'b0, clamp_reg};
            3: return {1'b0, ctrl_reg};
            default: return {5'b0, pix_gain[(i-4)*6 +: 6]};
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, want);
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 8; i++) chk(tag, 32'(act(i)), 32'(exp_r[i]));
    endtask

    task automatic send_bit(logic b);
        ser_data = b;
        tick(3);
        ser_clk = 1'b1;
        tick(3);
        ser_clk = 1'b0;
        tick(2);
    endtask

    task automatic begin_frame(int a, logic rnw);
        load_n = 1'b0;
        tick(4);
        for (int i = 0; i < 3; i++) send_bit(a[i]);
        send_bit(rnw);
        send_bit(1'b0);
        send_bit(1'b0);
    endtask

    task automatic send_word(int a, logic [10:0] v, int nbits);
        for (int i = 0; i < nbits; i++) send_bit(v[i]);
    endtask

    task automatic end_frame();
        load_n = 1'b1;
        tick(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [10:0] v;
        int seed;
        for (int i = 0; i < 8; i++) exp_r[i] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R10: reset state
        check_all("R10 reset");
        chk("R10 clamp_en", 32'(clamp_en), 32'd1);

        // R1 R2 R3 R5: every start address with every run length
        seed = 1;
        for (int st = 0; st < 8; st++) begin
            for (int n = 1; n <= 8 - st; n++) begin
                logic [10:0] nv [8];
                begin_frame(st, 1'b0);
                for (int k = 0; k < n; k++) begin
                    nv[st+k] = gen(st + k, seed);
                    send_word(st + k, nv[st+k], blen(st + k));
                end
                check_all("R5 hold before strobe");
                end_frame();
                for (int k = 0; k < n; k++) exp_r[st+k] = nv[st+k];
                check_all("R1 R2 R3 stream");
                seed++;
            end
        end

        // R4: bits past address 7 are ignored
        begin_frame(6, 1'b0);
        exp_r[6] = 11'h015;
        exp_r[7] = 11'h02a;
        send_word(6, exp_r[6], 6);
        send_word(7, exp_r[7], 6);
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        end_frame();
        check_all("R4 stop after top");

        // R6: partial payload discarded, complete one kept
        begin_frame(2, 1'b0);
        exp_r[2] = 8'hc3;
        send_word(2, exp_r[2], 8);
        send_word(3, 11'h3ff, 5);
        end_frame();
        check_all("R6 partial discard");

        // R7: read frame ignored
        begin_frame(1, 1'b1);
        send_word(1, 11'h155, 10);
        send_word(2, 11'h0aa, 8);
        end_frame();
        check_all("R7 read ignored");

        // R9: decoded operation fields, reset bit kept clear
        for (int s = 0; s < 64; s++) begin
            if (s[4]) continue;
            v = 11'(s) | 11'h040;
            begin_frame(0, 1'b0);
            send_word(0, v, 11);
            end_frame();
            exp_r[0] = v;
            chk("R9 op_reg", 32'(op_reg), 32'(v));
            chk("R9 chan_sel", 32'(chan_sel), 32'(s & 3));
            chk("R9 pwr_mode", 32'(pwr_mode), 32'((s >> 2) & 3));
            chk("R9 clamp_en", 32'(clamp_en), 32'(((s >> 5) & 1) ^ 1));
        end

        // R8: reset bit clears the bank and itself
        begin_frame(0, 1'b0);
        send_word(0, 11'h053, 11);
        send_word(1, 11'h2aa, 10);
        end_frame();
        for (int i = 0; i < 8; i++) exp_r[i] = '0;
        check_all("R8 soft reset");
        chk("R8 clamp_en", 32'(clamp_en), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule